// File: doc/BRIEF.md
# Oversampled Phase-Picking Bit Recovery

This block recovers one data bit per bit-rate clock cycle from a serial stream that has been sampled blindly at five times the bit rate. Each cycle it receives a window of five consecutive samples, with sample 0 the oldest. It locates data transitions inside that window and also at the seam with the previous window. From those transitions it points a phase register at the sample farthest from the edge, which is the centre of the data eye. The bit at that phase is registered and presented with a valid flag.

A window with no transition keeps the current phase. A window with more than one transition gives no usable position and also keeps it. A single-edge window whose preferred phase lies two or more steps away must be confirmed by the next valid window before the pointer moves. This makes a glitch unable to swing the phase across the eye. A pointer that wraps across the window boundary means a bit was either sampled twice or skipped. The block flags this with a one-cycle drop or add strobe, which a downstream realignment stage consumes.

Top module: `ovs_phase_recover`

## Requirements
- R1: After reset the outputs `bit_o`, `bit_valid_o`, `add_o` and `drop_o` are 0, the phase pointer is 2 and the stored last sample of the previous window is 0.
- R2: An edge at position i (sample i differs from sample i-1) in a window that has exactly one edge gives a target phase of (i+2) mod 5. If the target is within one step of the current phase, circularly, it is adopted in that same window.
- R3: Edge position 0 compares sample 0 with sample 4 of the previous valid window.
- R4: A valid window with no edge leaves the phase unchanged.
- R5: A valid window with two or more edges leaves the phase unchanged and cancels any pending vote.
- R6: A single-edge target two steps from the current phase is adopted only when the immediately preceding valid window proposed the same target. Otherwise it is stored as a pending vote. Any other valid window clears the vote.
- R7: One cycle after a valid window, `bit_o` holds sample[phase] of that window, using the phase chosen for that window, and `bit_valid_o` is 1. After a cycle with `win_valid_i` low, `bit_valid_o` is 0, `bit_o` holds its value, and phase, vote and stored sample are unchanged.
- R8: A forward phase move (1 or 2 steps) that ends at a lower index, such as 4 to 0, raises `drop_o` for one cycle, together with the bit it concerns.
- R9: A backward phase move (1 or 2 steps) that ends at a higher index, such as 0 to 4, raises `add_o` for one cycle.
- R10: `add_o` and `drop_o` are never high together, and either one is high only while `bit_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_i | input | 5 | Sample window, bit k is sample k, sample 0 oldest |
| win_valid_i | input | 1 | Window present this cycle |
| bit_o | output | 1 | Recovered bit |
| bit_valid_o | output | 1 | Recovered bit valid |
| add_o | output | 1 | A bit was skipped and must be inserted downstream |
| drop_o | output | 1 | The bit in this cycle duplicates the previous one |

## Verification
The phase pointer can only be seen through the sample it picks. The bench therefore uses windows whose candidate samples differ. With such a window, a wrong pointer shows on `bit_o` in the very next cycle. A corrupt stored last sample or a stale vote does not show until the following edge window. There it appears as a held phase where a move was due, or the reverse, and one or two windows later as a wrong bit or a missing or extra add/drop strobe. The table is ordered so that every such latent state is read out within two windows.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

  typedef enum logic [1:0] {
    WRAP_NONE = 2'd0,
    WRAP_ADD  = 2'd1,
    WRAP_DROP = 2'd2
  } wrap_e;

  // Eye centre opposite an edge found at position idx.
  function automatic int unsigned center_of(int unsigned idx, int unsigned ns);
    return (idx + ns / 2) % ns;
  endfunction

  // Forward step count from one phase to another, modulo ns.
  function automatic int unsigned fwd_steps(int unsigned from, int unsigned to,
                                            int unsigned ns);
    return (to + ns - from) % ns;
  endfunction

  // Circular distance between two phases.
  function automatic int unsigned circ_dist(int unsigned a, int unsigned b,
                                            int unsigned ns);
    int unsigned f;
    f = fwd_steps(a, b, ns);
    return (f <= ns - f) ? f : ns - f;
  endfunction

  // Classify a pointer move as boundary crossing in either direction.
  function automatic wrap_e wrap_kind(int unsigned old_p, int unsigned new_p,
                                      int unsigned ns);
    int unsigned f;
    f = fwd_steps(old_p, new_p, ns);
    if (f == 0) return WRAP_NONE;
    if (f <= ns / 2) return (new_p < old_p) ? WRAP_DROP : WRAP_NONE;
    return (new_p > old_p) ? WRAP_ADD : WRAP_NONE;
  endfunction

endpackage

// File: rtl/ovs_edge_detect.sv
module ovs_edge_detect #(
  parameter int NS = 5,
  localparam int PW = $clog2(NS),
  localparam int CW = $clog2(NS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_vld,
  input  logic [NS-1:0] win,
  output logic [NS-1:0] edges,
  output logic [CW-1:0] edge_cnt,
  output logic [PW-1:0] edge_idx
);

  logic prev_q;

  // Seam with the previous window, then adjacent pairs inside.
  assign edges[0] = win[0] ^ prev_q;
  for (genvar g = 1; g < NS; g++) begin : g_pair
    assign edges[g] = win[g] ^ win[g-1];
  end

  always_comb begin
    edge_cnt = '0;
    edge_idx = '0;
    for (int i = 0; i < NS; i++) edge_cnt = edge_cnt + CW'(edges[i]);
    for (int i = NS - 1; i >= 0; i--) if (edges[i]) edge_idx = PW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b0;
    else if (win_vld) prev_q <= win[NS-1];
  end

  assert_seam_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |=> $stable(prev_q));

  assert_seam_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |=> prev_q == $past(win[NS-1]));

endmodule

// File: rtl/ovs_phase_ctrl.sv
module ovs_phase_ctrl #(
  parameter int NS = 5,
  localparam int PW = $clog2(NS),
  localparam int CW = $clog2(NS + 1),
  localparam logic [PW-1:0] PH_RST = PW'(NS / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_vld,
  input  logic [CW-1:0] edge_cnt,
  input  logic [PW-1:0] edge_idx,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_nx,
  output logic          add_ev,
  output logic          drop_ev
);

  logic [PW-1:0] target, cand_q;
  logic          cand_vld_q;
  logic          single, near, far, vote_ok, adopt;
  ovs_pkg::wrap_e wrap;

  assign single  = (edge_cnt == CW'(1));
  assign target  = PW'(ovs_pkg::center_of(32'(edge_idx), NS));
  assign near    = single && ovs_pkg::circ_dist(32'(phase_q), 32'(target), NS) <= 1;
  assign far     = single && !near;
  assign vote_ok = far && cand_vld_q && (cand_q == target);
  assign adopt   = win_vld && (near || vote_ok);
  assign phase_nx = adopt ? target : phase_q;
  assign wrap    = win_vld ? ovs_pkg::wrap_kind(32'(phase_q), 32'(phase_nx), NS)
                           : ovs_pkg::WRAP_NONE;
  assign add_ev  = (wrap == ovs_pkg::WRAP_ADD);
  assign drop_ev = (wrap == ovs_pkg::WRAP_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_RST;
      cand_q     <= '0;
      cand_vld_q <= 1'b0;
    end else if (win_vld) begin
      phase_q    <= phase_nx;
      cand_q     <= target;
      cand_vld_q <= far && !vote_ok;
    end
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PW'(NS));

  assert_hold_noedge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && edge_cnt == '0) |=> $stable(phase_q));

  assert_hold_multi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && edge_cnt > CW'(1)) |=> ($stable(phase_q) && !cand_vld_q));

  assert_vote_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && far && !cand_vld_q) |=> ($stable(phase_q) && cand_vld_q));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |=> ($stable(phase_q) && $stable(cand_vld_q)));

  assert_drop_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> phase_q < $past(phase_q));

  assert_add_higher_R9: assert property (@(posedge clk) disable iff (!rst_n)
    add_ev |=> phase_q > $past(phase_q));

endmodule

// File: rtl/ovs_bit_pick.sv
module ovs_bit_pick #(
  parameter int NS = 5,
  localparam int PW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_vld,
  input  logic [NS-1:0] win,
  input  logic [PW-1:0] phase_nx,
  input  logic          add_ev,
  input  logic          drop_ev,
  output logic          bit_o,
  output logic          bit_valid_o,
  output logic          add_o,
  output logic          drop_o
);

  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NS; i++) if (phase_nx == PW'(i)) picked = win[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      add_o       <= 1'b0;
      drop_o      <= 1'b0;
    end else begin
      bit_valid_o <= win_vld;
      add_o       <= win_vld && add_ev;
      drop_o      <= win_vld && drop_ev;
      if (win_vld) bit_o <= picked;
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |=> bit_valid_o);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |=> (!bit_valid_o && $stable(bit_o)));

endmodule

// File: rtl/ovs_phase_recover.sv
module ovs_phase_recover #(
  parameter int NS = 5,
  localparam int PW = $clog2(NS),
  localparam int CW = $clog2(NS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] win_i,
  input  logic          win_valid_i,
  output logic          bit_o,
  output logic          bit_valid_o,
  output logic          add_o,
  output logic          drop_o
);

  logic [NS-1:0] edges;
  logic [CW-1:0] edge_cnt;
  logic [PW-1:0] edge_idx, phase_q, phase_nx;
  logic          add_ev, drop_ev;

  ovs_edge_detect #(.NS(NS)) u_edge (
    .clk(clk), .rst_n(rst_n), .win_vld(win_valid_i), .win(win_i),
    .edges(edges), .edge_cnt(edge_cnt), .edge_idx(edge_idx)
  );

  ovs_phase_ctrl #(.NS(NS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .win_vld(win_valid_i),
    .edge_cnt(edge_cnt), .edge_idx(edge_idx),
    .phase_q(phase_q), .phase_nx(phase_nx),
    .add_ev(add_ev), .drop_ev(drop_ev)
  );

  ovs_bit_pick #(.NS(NS)) u_pick (
    .clk(clk), .rst_n(rst_n), .win_vld(win_valid_i), .win(win_i),
    .phase_nx(phase_nx), .add_ev(add_ev), .drop_ev(drop_ev),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .add_o(add_o), .drop_o(drop_o)
  );

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_o && drop_o));

  assert_strobe_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (add_o || drop_o) |-> bit_valid_o);

  assert_edge_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt == CW'(1)) |-> $onehot0(edges));

endmodule

// File: tb/tb_ovs_phase_recover.sv
module tb_ovs_phase_recover;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 15;

  typedef struct packed {
    logic [4:0] w;
    logic       b;
    logic       a;
    logic       d;
  } row_t;

  // Window written sample4..sample0; expected bit, add, drop.
  localparam row_t TBL [ROWS] = '{
    '{5'b00000, 1'b0, 1'b0, 1'b0},  // R4 quiet, phase 2
    '{5'b11000, 1'b0, 1'b0, 1'b0},  // R6 far target 0 -> vote stored
    '{5'b00111, 1'b1, 1'b0, 1'b0},  // R6 confirmed, phase 0
    '{5'b10000, 1'b0, 1'b0, 1'b0},  // R2 edge 4 -> phase 1
    '{5'b00111, 1'b1, 1'b0, 1'b0},  // R2 edge 3 -> phase 0
    '{5'b11100, 1'b1, 1'b1, 1'b0},  // R9 0 -> 4 add
    '{5'b00111, 1'b1, 1'b0, 1'b1},  // R8 4 -> 0 drop
    '{5'b00100, 1'b0, 1'b0, 1'b0},  // R5 two edges
    '{5'b11011, 1'b1, 1'b0, 1'b0},  // R5 three edges
    '{5'b11111, 1'b1, 1'b0, 1'b0},  // R4 quiet
    '{5'b00000, 1'b0, 1'b0, 1'b0},  // R3 seam edge, vote 2
    '{5'b11111, 1'b1, 1'b0, 1'b0},  // R3 seam edge again -> phase 2
    '{5'b00111, 1'b1, 1'b0, 1'b0},  // R6 vote 0 stored
    '{5'b00000, 1'b0, 1'b0, 1'b0},  // R6 quiet clears vote
    '{5'b11000, 1'b0, 1'b0, 1'b0}   // R6 vote stored afresh
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] win_i = '0;
  logic       win_valid_i = 1'b0;
  logic       bit_o, bit_valid_o, add_o, drop_o;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ovs_phase_recover dut (
    .clk(clk), .rst_n(rst_n), .win_i(win_i), .win_valid_i(win_valid_i),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .add_o(add_o), .drop_o(drop_o)
  );

  function automatic string row_tag(int i);
    case (i)
      0, 9:          return "R4";
      1, 2, 12, 13, 14: return "R6";
      3, 4:          return "R2";
      5:             return "R9";
      6:             return "R8";
      7, 8:          return "R5";
      default:       return "R3";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(logic [4:0] w, logic v);
    @(negedge clk);
    win_i = w;
    win_valid_i = v;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string tag, logic b, logic a, logic d);
    chk({tag, " bit"}, bit_o, b);
    chk("R7 valid", bit_valid_o, 1);
    chk("R9 add", add_o, a);
    chk("R8 drop", drop_o, d);
    chk("R10 exclusive", add_o & drop_o, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    win_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 bit", bit_o, 0);
    chk("R1 valid", bit_valid_o, 0);
    chk("R1 add", add_o, 0);
    chk("R1 drop", drop_o, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();

    for (int i = 0; i < ROWS; i++) begin
      apply(TBL[i].w, 1'b1);
      expect_out(row_tag(i), TBL[i].b, TBL[i].a, TBL[i].d);
    end

    // R7: idle window with a would-be seam edge changes nothing.
    apply(5'b00000, 1'b0);
    chk("R7 idle valid", bit_valid_o, 0);
    chk("R7 idle bit held", bit_o, 0);
    chk("R10 idle strobes", add_o | drop_o, 0);
    apply(5'b00111, 1'b1);              // pending vote 0 confirmed
    expect_out("R7 after idle", 1'b1, 1'b0, 1'b0);
    apply(5'b11001, 1'b1);              // multi-edge: sample0 if phase 0
    expect_out("R7 phase after idle", 1'b1, 1'b0, 1'b0);

    // R1: reset restores phase 2 and seam sample 0.
    do_reset();
    apply(5'b11011, 1'b1);              // multi-edge, sample2 = 0
    expect_out("R1 reset phase", 1'b0, 1'b0, 1'b0);

    // R8: far forward move 3 -> 0 through a vote raises drop.
    do_reset();
    apply(5'b11110, 1'b1);              // edge 1 -> phase 3
    expect_out("R2 to three", 1'b1, 1'b0, 1'b0);
    apply(5'b00111, 1'b1);              // far target 0, vote stored
    expect_out("R6 hold three", 1'b0, 1'b0, 1'b0);
    apply(5'b11000, 1'b1);              // confirmed, 3 -> 0
    expect_out("R8 far drop", 1'b0, 1'b0, 1'b1);
    apply(5'b11111, 1'b0);
    chk("R8 drop one cycle", drop_o, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule